// File: doc/BRIEF.md
# Critical-Word Line Request Splitter

This block sits between a cache that issues whole-line read requests and two downstream memory queues. One queue is fast and expensive, the other is slow and frugal. Each accepted line request becomes two child requests that are issued in the same cycle. Normally word 0 of the line is treated as the urgent part and is fetched through the fast queue, while the other words come through the slow queue. The fast copy of word 0 is handed back to the requester as early data as soon as it arrives. The complete line is delivered once both halves are present.

A small direct-mapped table of saturating counters, indexed by page, tracks how often each page is requested. Once a page's entry is high enough, the page is treated as hot. Its whole line is then fetched through the fast queue, and the slow queue receives a null placeholder request, so the pairing of child requests stays uniform. Up to four line requests may be in flight, each identified by a slot tag. The two queues may answer in any order, and the order may differ between them.

Top module: `cws_top`

## Requirements
- R1: Each accepted request (req_valid and req_ready high at a clock edge) drives fast_req_valid and slow_req_valid high in that same cycle. Both child requests carry the requester's line number and the same tag, and that tag equals req_slot.
- R2: A request to a page that is not hot drives fast_req_full=0, meaning only word 0 is wanted, and slow_req_null=0, meaning words 1 to 3 are wanted.
- R3: A request to a hot page drives fast_req_full=1, meaning the whole line comes from the fast side, and slow_req_null=1. The slow response for a null request is still required, but its data is discarded.
- R4: The page table has 16 counters of 4 bits each, indexed by line-number bits [11:8] with no tag compare. Every accepted request increments its counter, which saturates at 15. A request is hot when its counter holds 12 or more before the increment.
- R5: One cycle after an accepted fast response, early_valid is high for one cycle, with early_slot set to the response tag and early_word set to fast_rsp_data[31:0].
- R6: One cycle after both halves of a slot have been recorded, line_valid is high with line_slot and line_data, and the slot becomes free. For a cold line, line_data[31:0] comes from the fast response and bits [127:32] come from slow_rsp_data. For a hot line, all 128 bits come from the fast response. If several slots complete together, the lowest slot is delivered first and the others follow one per cycle.
- R7: Fast and slow responses may arrive in either order, for any live tag, and may interleave across tags.
- R8: req_ready is low, and no child request is issued, while fast_req_ready is low, while slow_req_ready is low, or while all four slots are busy.
- R9: A new request takes the lowest-numbered free slot.
- R10: Reset frees all slots, clears all page counters and deasserts every valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Line request present |
| req_ready | output | 1 | Line request can be taken this cycle |
| req_line | input | 28 | Line number of the request (byte address / 16) |
| req_slot | output | 2 | Tag the request receives if accepted |
| fast_req_valid | output | 1 | Child request to the fast queue |
| fast_req_ready | input | 1 | Fast queue can take a request |
| fast_req_line | output | 28 | Line number sent to the fast queue |
| fast_req_tag | output | 2 | Slot tag for the fast child |
| fast_req_full | output | 1 | 1: whole line wanted, 0: word 0 only |
| slow_req_valid | output | 1 | Child request to the slow queue |
| slow_req_ready | input | 1 | Slow queue can take a request |
| slow_req_line | output | 28 | Line number sent to the slow queue |
| slow_req_tag | output | 2 | Slot tag for the slow child |
| slow_req_null | output | 1 | 1: placeholder, no data needed |
| fast_rsp_valid | input | 1 | Fast queue response present |
| fast_rsp_tag | input | 2 | Tag of the fast response |
| fast_rsp_data | input | 128 | Fast data, word 0 in bits [31:0] |
| slow_rsp_valid | input | 1 | Slow queue response present |
| slow_rsp_tag | input | 2 | Tag of the slow response |
| slow_rsp_data | input | 96 | Words 1 to 3, word 1 in bits [31:0] |
| early_valid | output | 1 | Urgent word delivered |
| early_slot | output | 2 | Slot of the urgent word |
| early_word | output | 32 | Urgent word value |
| line_valid | output | 1 | Complete line delivered |
| line_slot | output | 2 | Slot of the complete line |
| line_data | output | 128 | Complete line |

## Verification
The hardest case to reach from the ports is two slots that finish in the same clock edge. This calls for one slot to be completed by its fast half and another by its slow half in that very cycle. The stimulus reaches it by first returning the opposite halves of both slots, then driving the two remaining responses together, and then checking the two line deliveries on consecutive cycles with the lowest slot first. The hot threshold is reached by sending twelve warm-up requests to one page. An aliasing page then confirms that the table keeps no tags, and a final reset confirms that the counters clear.

// File: rtl/cws_pkg.sv
package cws_pkg;

    localparam int ADDR_W      = 32;
    localparam int WORD_W      = 32;
    localparam int LINE_WORDS  = 4;
    localparam int SLOTS       = 4;
    localparam int PAGE_LSB    = 12;
    localparam int HOT_ENTRIES = 16;
    localparam int CNT_W       = 4;
    localparam int HOT_LEVEL   = 12;

    // Per-slot tracking state, independent of data widths.
    typedef struct packed {
        logic busy;
        logic hot;
        logic got_fast;
        logic got_slow;
    } slot_state_t;

    // Route chosen for a line request.
    typedef enum logic {
        ROUTE_SPLIT = 1'b0,
        ROUTE_WHOLE = 1'b1
    } route_e;

    function automatic route_e pick_route(input logic hot);
        return hot ? ROUTE_WHOLE : ROUTE_SPLIT;
    endfunction

endpackage

// File: rtl/cws_hot_table.sv
module cws_hot_table
    import cws_pkg::*;
#(
    parameter int ENTRIES = cws_pkg::HOT_ENTRIES,
    parameter int CW      = cws_pkg::CNT_W,
    parameter int LEVEL   = cws_pkg::HOT_LEVEL,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic             bump,
    output logic             is_hot
);

    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [CW-1:0] CNT_HOT = CW'(LEVEL);

    logic [CW-1:0] cnt [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) cnt[e] <= '0;
        end else if (bump && cnt[lk_idx] != CNT_MAX) begin
            cnt[lk_idx] <= cnt[lk_idx] + 1'b1;
        end
    end

    // Classification uses the count held before this access.
    assign is_hot = (cnt[lk_idx] >= CNT_HOT);

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
            AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
                (cnt[e] != $past(cnt[e])) |-> (cnt[e] == CW'($past(cnt[e]) + 1'b1)));  // R4
            AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
                (bump && lk_idx == IDX_W'(e) && cnt[e] == CNT_MAX) |=> (cnt[e] == CNT_MAX));  // R4
        end
    endgenerate

endmodule

// File: rtl/cws_tracker.sv
module cws_tracker
    import cws_pkg::*;
#(
    parameter int NSLOT  = cws_pkg::SLOTS,
    parameter int WW     = cws_pkg::WORD_W,
    parameter int NWORD  = cws_pkg::LINE_WORDS,
    localparam int SW    = $clog2(NSLOT),
    localparam int LW    = WW * NWORD,
    localparam int RW    = LW - WW
) (
    input  logic          clk,
    input  logic          rst,
    // allocation side
    input  logic          alloc,
    input  logic          alloc_hot,
    output logic          free_any,
    output logic [SW-1:0] free_idx,
    // returning halves
    input  logic          fr_valid,
    input  logic [SW-1:0] fr_tag,
    input  logic [LW-1:0] fr_data,
    input  logic          sr_valid,
    input  logic [SW-1:0] sr_tag,
    input  logic [RW-1:0] sr_data,
    // requester side
    output logic          early_valid,
    output logic [SW-1:0] early_slot,
    output logic [WW-1:0] early_word,
    output logic          line_valid,
    output logic [SW-1:0] line_slot,
    output logic [LW-1:0] line_data
);

    slot_state_t   st   [NSLOT];
    logic [LW-1:0] lbuf [NSLOT];

    logic [NSLOT-1:0] busy_v, gotf_v, gots_v, done_v;
    logic             drain_any;
    logic [SW-1:0]    drain_idx;
    logic             fast_take, slow_take;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            busy_v[i] = st[i].busy;
            gotf_v[i] = st[i].got_fast;
            gots_v[i] = st[i].got_slow;
            done_v[i] = st[i].busy && st[i].got_fast && st[i].got_slow;
        end
    end

    // Lowest free slot for allocation, lowest finished slot for delivery.
    always_comb begin
        free_any  = 1'b0;
        free_idx  = '0;
        drain_any = 1'b0;
        drain_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!busy_v[i]) begin
                free_any = 1'b1;
                free_idx = SW'(i);
            end
            if (done_v[i]) begin
                drain_any = 1'b1;
                drain_idx = SW'(i);
            end
        end
    end

    assign fast_take = fr_valid && busy_v[fr_tag] && !gotf_v[fr_tag];
    assign slow_take = sr_valid && busy_v[sr_tag] && !gots_v[sr_tag];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) st[i] <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (drain_any && drain_idx == SW'(i)) begin
                    st[i] <= '0;
                end else if (alloc && free_idx == SW'(i)) begin
                    st[i].busy     <= 1'b1;
                    st[i].hot      <= alloc_hot;
                    st[i].got_fast <= 1'b0;
                    st[i].got_slow <= 1'b0;
                end else begin
                    if (fast_take && fr_tag == SW'(i)) st[i].got_fast <= 1'b1;
                    if (slow_take && sr_tag == SW'(i)) st[i].got_slow <= 1'b1;
                end
            end
        end
    end

    // Line assembly: fast half fills word 0 (or all of a hot line),
    // slow half fills the remaining words of a cold line only.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (fast_take && fr_tag == SW'(i)) begin
                if (st[i].hot) lbuf[i] <= fr_data;
                else           lbuf[i][WW-1:0] <= fr_data[WW-1:0];
            end
            if (slow_take && sr_tag == SW'(i) && !st[i].hot) begin
                lbuf[i][LW-1:WW] <= sr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            early_valid <= 1'b0;
            line_valid  <= 1'b0;
        end else begin
            early_valid <= fast_take;
            line_valid  <= drain_any;
        end
    end

    always_ff @(posedge clk) begin
        early_slot <= fr_tag;
        early_word <= fr_data[WW-1:0];
        line_slot  <= drain_idx;
        line_data  <= lbuf[drain_idx];
    end

    AST_EARLY_AFTER_FAST: assert property (@(posedge clk) disable iff (rst)
        early_valid |-> $past(fr_valid));  // R5
    AST_LINE_SLOT_FREED: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> !busy_v[line_slot]);  // R6
    AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !busy_v[free_idx]);  // R9
    AST_FAST_TAG_LIVE: assert property (@(posedge clk) disable iff (rst)
        fr_valid |-> (busy_v[fr_tag] && !gotf_v[fr_tag]));  // R7
    AST_SLOW_TAG_LIVE: assert property (@(posedge clk) disable iff (rst)
        sr_valid |-> (busy_v[sr_tag] && !gots_v[sr_tag]));  // R7

endmodule

// File: rtl/cws_top.sv
module cws_top
    import cws_pkg::*;
#(
    parameter int AW       = cws_pkg::ADDR_W,
    parameter int WW       = cws_pkg::WORD_W,
    parameter int NWORD    = cws_pkg::LINE_WORDS,
    parameter int NSLOT    = cws_pkg::SLOTS,
    parameter int PG_LSB   = cws_pkg::PAGE_LSB,
    parameter int NHOT     = cws_pkg::HOT_ENTRIES,
    parameter int CW       = cws_pkg::CNT_W,
    parameter int LEVEL    = cws_pkg::HOT_LEVEL,
    localparam int SW      = $clog2(NSLOT),
    localparam int LW      = WW * NWORD,
    localparam int RW      = LW - WW,
    localparam int OFF_W   = $clog2(LW / 8),
    localparam int LA_W    = AW - OFF_W,
    localparam int IDX_W   = $clog2(NHOT),
    localparam int IDX_LSB = PG_LSB - OFF_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [LA_W-1:0] req_line,
    output logic [SW-1:0]   req_slot,
    output logic            fast_req_valid,
    input  logic            fast_req_ready,
    output logic [LA_W-1:0] fast_req_line,
    output logic [SW-1:0]   fast_req_tag,
    output logic            fast_req_full,
    output logic            slow_req_valid,
    input  logic            slow_req_ready,
    output logic [LA_W-1:0] slow_req_line,
    output logic [SW-1:0]   slow_req_tag,
    output logic            slow_req_null,
    input  logic            fast_rsp_valid,
    input  logic [SW-1:0]   fast_rsp_tag,
    input  logic [LW-1:0]   fast_rsp_data,
    input  logic            slow_rsp_valid,
    input  logic [SW-1:0]   slow_rsp_tag,
    input  logic [RW-1:0]   slow_rsp_data,
    output logic            early_valid,
    output logic [SW-1:0]   early_slot,
    output logic [WW-1:0]   early_word,
    output logic            line_valid,
    output logic [SW-1:0]   line_slot,
    output logic [LW-1:0]   line_data
);

    logic          free_any;
    logic [SW-1:0] free_idx;
    logic          page_hot;
    logic          fire;
    route_e        route;

    cws_hot_table #(
        .ENTRIES (NHOT),
        .CW      (CW),
        .LEVEL   (LEVEL)
    ) u_hot (
        .clk    (clk),
        .rst    (rst),
        .lk_idx (req_line[IDX_LSB +: IDX_W]),
        .bump   (fire),
        .is_hot (page_hot)
    );

    cws_tracker #(
        .NSLOT (NSLOT),
        .WW    (WW),
        .NWORD (NWORD)
    ) u_trk (
        .clk         (clk),
        .rst         (rst),
        .alloc       (fire),
        .alloc_hot   (page_hot),
        .free_any    (free_any),
        .free_idx    (free_idx),
        .fr_valid    (fast_rsp_valid),
        .fr_tag      (fast_rsp_tag),
        .fr_data     (fast_rsp_data),
        .sr_valid    (slow_rsp_valid),
        .sr_tag      (slow_rsp_tag),
        .sr_data     (slow_rsp_data),
        .early_valid (early_valid),
        .early_slot  (early_slot),
        .early_word  (early_word),
        .line_valid  (line_valid),
        .line_slot   (line_slot),
        .line_data   (line_data)
    );

    // Both children leave together or not at all.
    assign req_ready = fast_req_ready && slow_req_ready && free_any;
    assign fire      = req_valid && req_ready;
    assign req_slot  = free_idx;
    assign route     = pick_route(page_hot);

    assign fast_req_valid = fire;
    assign fast_req_line  = req_line;
    assign fast_req_tag   = free_idx;
    assign fast_req_full  = (route == ROUTE_WHOLE);

    assign slow_req_valid = fire;
    assign slow_req_line  = req_line;
    assign slow_req_tag   = free_idx;
    assign slow_req_null  = (route == ROUTE_WHOLE);

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        !free_any |-> (!fast_req_valid && !slow_req_valid));  // R8
    AST_QUEUE_STALL: assert property (@(posedge clk) disable iff (rst)
        (!fast_req_ready || !slow_req_ready) |-> !req_ready);  // R8
    AST_EARLY_NOT_STUCK: assert property (@(posedge clk) disable iff (rst)
        early_valid |=> (!early_valid || $past(fast_rsp_valid)));  // R5

endmodule

// File: tb/cws_top_tb.sv
module cws_top_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic         req_ready;
    logic [27:0]  req_line;
    logic [1:0]   req_slot;
    logic         fast_req_valid, fast_req_ready, fast_req_full;
    logic [27:0]  fast_req_line;
    logic [1:0]   fast_req_tag;
    logic         slow_req_valid, slow_req_ready, slow_req_null;
    logic [27:0]  slow_req_line;
    logic [1:0]   slow_req_tag;
    logic         fast_rsp_valid;
    logic [1:0]   fast_rsp_tag;
    logic [127:0] fast_rsp_data;
    logic         slow_rsp_valid;
    logic [1:0]   slow_rsp_tag;
    logic [95:0]  slow_rsp_data;
    logic         early_valid;
    logic [1:0]   early_slot;
    logic [31:0]  early_word;
    logic         line_valid;
    logic [1:0]   line_slot;
    logic [127:0] line_data;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cws_top u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line), .req_slot(req_slot),
        .fast_req_valid(fast_req_valid), .fast_req_ready(fast_req_ready),
        .fast_req_line(fast_req_line), .fast_req_tag(fast_req_tag), .fast_req_full(fast_req_full),
        .slow_req_valid(slow_req_valid), .slow_req_ready(slow_req_ready),
        .slow_req_line(slow_req_line), .slow_req_tag(slow_req_tag), .slow_req_null(slow_req_null),
        .fast_rsp_valid(fast_rsp_valid), .fast_rsp_tag(fast_rsp_tag), .fast_rsp_data(fast_rsp_data),
        .slow_rsp_valid(slow_rsp_valid), .slow_rsp_tag(slow_rsp_tag), .slow_rsp_data(slow_rsp_data),
        .early_valid(early_valid), .early_slot(early_slot), .early_word(early_word),
        .line_valid(line_valid), .line_slot(line_slot), .line_data(line_data)
    );

    typedef struct packed {
        logic [27:0] line;
        logic        hot;
        logic        fast_first;
    } vec_t;

    // Walked after 12 warm-up requests to page index 5.
    localparam vec_t VECS [6] = '{
        '{line: 28'h0000504, hot: 1'b1, fast_first: 1'b1},  // 13th access: hot
        '{line: 28'h0000708, hot: 1'b0, fast_first: 1'b0},
        '{line: 28'h0001500, hot: 1'b1, fast_first: 1'b0},  // aliases index 5
        '{line: 28'h000050C, hot: 1'b1, fast_first: 1'b1},
        '{line: 28'h0000500, hot: 1'b1, fast_first: 1'b0},  // saturated
        '{line: 28'h0000A01, hot: 1'b0, fast_first: 1'b1}
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [127:0] fpat(input int n);
        return {32'hFA00_0300 + 32'(n), 32'hFA00_0200 + 32'(n),
                32'hFA00_0100 + 32'(n), 32'hFA00_0000 + 32'(n)};
    endfunction

    function automatic logic [95:0] spat(input int n);
        return {32'h5B00_0300 + 32'(n), 32'h5B00_0200 + 32'(n), 32'h5B00_0100 + 32'(n)};
    endfunction

    function automatic logic [127:0] merged(input int n, input bit hot);
        logic [127:0] f = fpat(n);
        return hot ? f : {spat(n), f[31:0]};
    endfunction

    task automatic issue(input logic [27:0] ln, input logic [1:0] tag, input bit hot, input string rq);
        @(negedge clk);
        req_valid = 1'b1;
        req_line  = ln;
        #1;
        chk(req_ready == 1'b1, "R8", "req_ready", 128'(req_ready), 128'(1));
        chk(fast_req_valid && slow_req_valid, "R1", "paired valid",
            128'({fast_req_valid, slow_req_valid}), 128'(3));
        chk(fast_req_line == ln && slow_req_line == ln, "R1", "child line",
            128'(fast_req_line), 128'(ln));
        chk(fast_req_tag == tag && slow_req_tag == tag && req_slot == tag, "R9", "tag",
            128'(fast_req_tag), 128'(tag));
        chk(fast_req_full == hot, rq, "fast_req_full", 128'(fast_req_full), 128'(hot));
        chk(slow_req_null == hot, rq, "slow_req_null", 128'(slow_req_null), 128'(hot));
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic send_fast(input logic [1:0] tag, input logic [127:0] d);
        fast_rsp_valid = 1'b1;
        fast_rsp_tag   = tag;
        fast_rsp_data  = d;
    endtask

    task automatic send_slow(input logic [1:0] tag, input logic [95:0] d);
        slow_rsp_valid = 1'b1;
        slow_rsp_tag   = tag;
        slow_rsp_data  = d;
    endtask

    task automatic idle_rsp();
        fast_rsp_valid = 1'b0;
        slow_rsp_valid = 1'b0;
    endtask

    task automatic check_line(input logic [1:0] tag, input logic [127:0] exp);
        chk(line_valid == 1'b1, "R6", "line_valid", 128'(line_valid), 128'(1));
        chk(line_slot == tag, "R6", "line_slot", 128'(line_slot), 128'(tag));
        chk(line_data == exp, "R6", "line_data", line_data, exp);
    endtask

    // Completes one slot; the opposite order exercises R7.
    task automatic complete(input logic [1:0] tag, input int n, input bit hot, input bit fast_first);
        logic [127:0] f = fpat(n);
        @(negedge clk);
        if (fast_first) send_fast(tag, f); else send_slow(tag, spat(n) ^ {96{hot}});
        @(posedge clk); #1; idle_rsp();
        @(negedge clk);
        if (fast_first) begin
            chk(early_valid && early_slot == tag && early_word == f[31:0], "R5", "early word",
                128'(early_word), 128'(f[31:0]));
            send_slow(tag, spat(n) ^ {96{hot}});
        end else begin
            chk(early_valid == 1'b0, "R7", "no early from slow", 128'(early_valid), 128'(0));
            send_fast(tag, f);
        end
        @(posedge clk); #1; idle_rsp();
        @(negedge clk);
        if (!fast_first)
            chk(early_valid && early_slot == tag && early_word == f[31:0], "R5", "early word",
                128'(early_word), 128'(f[31:0]));
        chk(line_valid == 1'b0, "R6", "line one cycle late", 128'(line_valid), 128'(0));
        @(negedge clk);
        check_line(tag, hot ? f : merged(n, 1'b0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_line = '0;
        fast_req_ready = 1'b1;
        slow_req_ready = 1'b1;
        idle_rsp();
        fast_rsp_tag = '0;
        slow_rsp_tag = '0;
        fast_rsp_data = '0;
        slow_rsp_data = '0;
        do_reset();

        // R10: reset state
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after reset", 128'(req_ready), 128'(1));
        chk(!fast_req_valid && !slow_req_valid, "R10", "no child valid", 128'(fast_req_valid), 128'(0));
        chk(!early_valid && !line_valid, "R10", "no response valid",
            128'({early_valid, line_valid}), 128'(0));
        chk(req_slot == 2'd0, "R10", "all slots free", 128'(req_slot), 128'(0));

        // R4: twelve warm-up accesses to page index 5 stay cold (R2)
        for (int k = 0; k < 12; k++) begin
            issue(28'h500 + 28'(k), 2'd0, 1'b0, "R2");
            complete(2'd0, 100 + k, 1'b0, k[0]);
        end

        // Table walk: hot threshold, aliasing, saturation, R3 null data ignored
        for (int i = 0; i < 6; i++) begin
            issue(VECS[i].line, 2'd0, VECS[i].hot, VECS[i].hot ? "R3" : "R2");
            complete(2'd0, i, VECS[i].hot, VECS[i].fast_first);
        end

        // R8: backpressure from either queue blocks issue
        @(negedge clk);
        req_valid = 1'b1; req_line = 28'h0000900; fast_req_ready = 1'b0;
        #1;
        chk(!req_ready && !fast_req_valid && !slow_req_valid, "R8", "fast queue stall",
            128'({req_ready, fast_req_valid, slow_req_valid}), 128'(0));
        @(negedge clk);
        fast_req_ready = 1'b1; slow_req_ready = 1'b0;
        #1;
        chk(!req_ready && !fast_req_valid && !slow_req_valid, "R8", "slow queue stall",
            128'({req_ready, fast_req_valid, slow_req_valid}), 128'(0));
        @(posedge clk); #1;
        req_valid = 1'b0; slow_req_ready = 1'b1;

        // R6: two slots finishing on the same edge, lowest first
        issue(28'h0000900, 2'd0, 1'b0, "R2");
        issue(28'h0000901, 2'd1, 1'b0, "R9");
        @(negedge clk); send_slow(2'd0, spat(40)); @(posedge clk); #1; idle_rsp();
        @(negedge clk); send_fast(2'd1, fpat(41)); @(posedge clk); #1; idle_rsp();
        @(negedge clk); send_fast(2'd0, fpat(40)); send_slow(2'd1, spat(41));
        @(posedge clk); #1; idle_rsp();
        @(negedge clk);
        chk(early_valid && early_slot == 2'd0, "R5", "early slot 0", 128'(early_slot), 128'(0));
        chk(line_valid == 1'b0, "R6", "no line yet", 128'(line_valid), 128'(0));
        @(negedge clk); check_line(2'd0, merged(40, 1'b0));
        @(negedge clk); check_line(2'd1, merged(41, 1'b0));
        @(negedge clk);
        chk(line_valid == 1'b0, "R6", "single delivery each", 128'(line_valid), 128'(0));

        // R8/R9: fill all four slots, then stall
        issue(28'h0000B00, 2'd0, 1'b0, "R9");
        issue(28'h0000B01, 2'd1, 1'b0, "R9");
        issue(28'h0000C00, 2'd2, 1'b0, "R9");
        issue(28'h0000D00, 2'd3, 1'b0, "R9");
        @(negedge clk);
        req_valid = 1'b1; req_line = 28'h0000E00;
        #1;
        chk(!req_ready && !fast_req_valid, "R8", "table full stall",
            128'({req_ready, fast_req_valid}), 128'(0));
        @(posedge clk); #1; req_valid = 1'b0;
        // R7: complete slot 2 out of order, freed slot is reused
        complete(2'd2, 52, 1'b0, 1'b0);
        issue(28'h0000E00, 2'd2, 1'b0, "R9");
        complete(2'd3, 53, 1'b0, 1'b1);
        complete(2'd0, 50, 1'b0, 1'b0);
        complete(2'd1, 51, 1'b0, 1'b1);
        complete(2'd2, 54, 1'b0, 1'b0);

        // R10: reset clears the page counters
        do_reset();
        issue(28'h0000500, 2'd0, 1'b0, "R10");
        complete(2'd0, 60, 1'b0, 1'b1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule